// File: doc/BRIEF.md
# UART Automatic Flow Controller

This block gives one UART channel automatic hardware handshaking. On the receive side it compares the fill count of a 16-byte receive FIFO against a trigger level picked by a 2-bit code. It raises a receive-threshold interrupt when the fill reaches that level. It also drives the request-to-send line with hysteresis: the line goes to the stop level one rung up the trigger ladder and returns to the go level only when the fill has drained below the level minus one. While automatic RTS is off, the line simply follows a software value.

On the transmit side, the clear-to-send input passes through a two-flop synchronizer. A gate then turns it into a transmit-permit level that the serializer samples before it starts each character. The gate changes state only while the serializer reports that it is idle between characters, so a character that has begun always completes. The two automatic features have separate enables.

The RTS controller has two states. `RTS_GO` drives 0; when automatic RTS is on and the fill is at or above the stop level, it moves to `RTS_STOP`. `RTS_STOP` drives 1; when the fill falls below the resume level, it moves back to `RTS_GO`. Turning automatic RTS off forces `RTS_GO`. The transmit gate also has two states. `TX_OPEN` permits transmission; when idle with automatic CTS on and the synchronized CTS at 1, it moves to `TX_HOLD`. `TX_HOLD` blocks transmission; when idle with either automatic CTS off or the synchronized CTS at 0, it moves back to `TX_OPEN`.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, `tx_permit` is 1, `rx_thresh_irq` is 0 and the RTS controller is in `RTS_GO`.
- R2: `trig_sel` codes the programmed level as 00→1, 01→4, 10→8 and 11→14 bytes. The stop level is the next rung up: 4, 8, 14, or 16 (full) for code 11.
- R3: `rx_thresh_irq` is 1 in the cycle after an edge at which `auto_rts_en` is 1 and `rx_count` ≥ the programmed level, and is 0 after any other edge.
- R4: With `auto_rts_en` at 1, `rts_out` is 1 in the cycle after an edge at which `rx_count` ≥ the stop level.
- R5: With `auto_rts_en` at 1, `rts_out` is 0 in the cycle after an edge at which `rx_count` < the resume level. The resume level is the programmed level minus one, except that it is 1 for code 00.
- R6: With `auto_rts_en` at 1, a fill that lies at or above the resume level and below the stop level keeps the previous `rts_out` value.
- R7: With `auto_rts_en` at 0, `rts_out` equals `sw_rts` in the same cycle, and the controller is held in `RTS_GO`. Re-enabling with a fill between the thresholds therefore gives `rts_out` = 0.
- R8: `cts_in` passes through two synchronizer flops. A change on `cts_in` reaches `tx_permit` at the third rising edge after it, provided `tx_idle` is 1.
- R9: With `auto_cts_en` at 1 and `tx_idle` at 1, a synchronized CTS of 1 drives `tx_permit` to 0, and a synchronized CTS of 0 drives it back to 1.
- R10: While `tx_idle` is 0, `tx_permit` does not change.
- R11: With `auto_cts_en` at 0, `tx_permit` is 1 one edge after `tx_idle` is 1, whatever `cts_in` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 5 | Receive FIFO fill, 0 to 16 |
| trig_sel | input | 2 | Programmed trigger level code |
| auto_cts_en | input | 1 | Enable for automatic CTS gating |
| auto_rts_en | input | 1 | Enable for automatic RTS and the threshold interrupt |
| sw_rts | input | 1 | Software RTS value, used when automatic RTS is off |
| cts_in | input | 1 | Asynchronous clear-to-send line, 1 means stop |
| tx_idle | input | 1 | Serializer is between characters |
| rts_out | output | 1 | Request-to-send line, 1 means stop |
| tx_permit | output | 1 | Serializer may start a new character |
| rx_thresh_irq | output | 1 | Receive-threshold interrupt |

## Verification
The hardest situation to reach is the top rung of the ladder. With code 11, stopping needs a completely full FIFO, and resuming needs the fill to drain from 16 all the way to 12. In between, the fill has to sit at 13, 14 and 15 so that the held value can be observed. The bench reaches this by stepping `rx_count` directly through the same stop/hold/release sequence for every code, so that each rung's stop and resume edges are checked in turn. A second hard case is a CTS change while a character is in flight. The bench holds `tx_idle` low well past the synchronizer delay before opening the boundary.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    typedef enum logic {
        RTS_GO   = 1'b0,
        RTS_STOP = 1'b1
    } rts_state_t;

    typedef enum logic {
        TX_OPEN = 1'b0,
        TX_HOLD = 1'b1
    } tx_state_t;

    // programmed level on the ladder
    function automatic int unsigned prog_level(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    // one rung above the programmed level; top rung is a full FIFO
    function automatic int unsigned stop_level(input logic [1:0] sel, input int unsigned depth);
        unique case (sel)
            2'd0:    return 4;
            2'd1:    return 8;
            2'd2:    return 14;
            default: return depth;
        endcase
    endfunction

    // fill must be strictly below this to resume
    function automatic int unsigned resume_level(input logic [1:0] sel);
        return (sel == 2'd0) ? 1 : prog_level(sel) - 1;
    endfunction

endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = shreg[LAST];
endmodule

// File: rtl/uart_fc_rts_fsm.sv
module uart_fc_rts_fsm
    import uart_fc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             sw_rts,
    input  logic [CNT_W-1:0] fill,
    input  logic [1:0]       sel,
    output logic             rts,
    output logic             irq
);
    rts_state_t       state_q, state_d;
    logic [CNT_W-1:0] lvl_prog, lvl_stop, lvl_resume;
    logic             irq_q;

    always_comb begin
        lvl_prog   = CNT_W'(prog_level(sel));
        lvl_stop   = CNT_W'(stop_level(sel, FIFO_DEPTH));
        lvl_resume = CNT_W'(resume_level(sel));
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!auto_en) begin
            state_d = RTS_GO;
        end else begin
            unique case (state_q)
                RTS_GO:   if (fill >= lvl_stop)  state_d = RTS_STOP;
                RTS_STOP: if (fill < lvl_resume) state_d = RTS_GO;
                default:  state_d = RTS_GO;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RTS_GO;
        else        state_q <= state_d;
    end

    // threshold interrupt register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= auto_en && (fill >= lvl_prog);
    end

    // outputs
    always_comb begin
        irq = irq_q;
        if (auto_en) rts = (state_q == RTS_STOP);
        else         rts = sw_rts;
    end
endmodule

// File: rtl/uart_fc_tx_gate.sv
module uart_fc_tx_gate
    import uart_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_s,
    input  logic idle,
    output logic permit
);
    tx_state_t state_q, state_d;

    // next state: moves only at character boundaries
    always_comb begin
        state_d = state_q;
        if (idle) begin
            unique case (state_q)
                TX_OPEN: if (auto_en && cts_s)   state_d = TX_HOLD;
                TX_HOLD: if (!auto_en || !cts_s) state_d = TX_OPEN;
                default: state_d = TX_OPEN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_OPEN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        permit = (state_q == TX_OPEN);
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             auto_cts_en,
    input  logic             auto_rts_en,
    input  logic             sw_rts,
    input  logic             cts_in,
    input  logic             tx_idle,
    output logic             rts_out,
    output logic             tx_permit,
    output logic             rx_thresh_irq
);
    logic cts_synced;

    uart_fc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cts_in),
        .q     (cts_synced)
    );

    uart_fc_tx_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_en (auto_cts_en),
        .cts_s   (cts_synced),
        .idle    (tx_idle),
        .permit  (tx_permit)
    );

    uart_fc_rts_fsm #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_rts (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_en (auto_rts_en),
        .sw_rts  (sw_rts),
        .fill    (rx_count),
        .sel     (trig_sel),
        .rts     (rts_out),
        .irq     (rx_thresh_irq)
    );
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk
    import uart_fc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_count,
    input logic [1:0]       trig_sel,
    input logic             auto_cts_en,
    input logic             auto_rts_en,
    input logic             sw_rts,
    input logic             cts_in,
    input logic             tx_idle,
    input logic             rts_out,
    input logic             tx_permit,
    input logic             rx_thresh_irq
);
    logic at_prog, at_stop, below_res, in_band;

    always_comb begin
        at_prog   = 32'(rx_count) >= prog_level(trig_sel);
        at_stop   = 32'(rx_count) >= stop_level(trig_sel, FIFO_DEPTH);
        below_res = 32'(rx_count) <  resume_level(trig_sel);
        in_band   = !below_res && !at_stop;
    end

    // R3
    a_r3_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && at_prog) |=> rx_thresh_irq);
    a_r3_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !(auto_rts_en && at_prog) |=> !rx_thresh_irq);

    // R4
    a_r4_rts_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && at_stop) |=> (!auto_rts_en || rts_out));

    // R5
    a_r5_rts_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && below_res) |=> (!auto_rts_en || !rts_out));

    // R6
    a_r6_rts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && in_band) |=> (!auto_rts_en || $stable(rts_out)));

    // R7
    a_r7_rts_reenable: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_rts_en && !at_stop) |=> (!auto_rts_en || !rts_out));

    // R10
    a_r10_gate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle |=> $stable(tx_permit));

    // R11
    a_r11_cts_off: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !auto_cts_en) |=> tx_permit);

    wire unused_ok = &{1'b0, sw_rts, cts_in};
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/uart_flow_ctrl_test.sv
`timescale 1ns/1ps
module uart_flow_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] rx_count = '0;
    logic [1:0] trig_sel = '0;
    logic       auto_cts_en = 1'b0, auto_rts_en = 1'b0, sw_rts = 1'b0;
    logic       cts_in = 1'b0, tx_idle = 1'b1;
    logic       rts_out, tx_permit, rx_thresh_irq;
    int         n_checks = 0, n_errors = 0;

    always #10 clk = ~clk;

    uart_flow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .trig_sel(trig_sel),
        .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en), .sw_rts(sw_rts),
        .cts_in(cts_in), .tx_idle(tx_idle), .rts_out(rts_out),
        .tx_permit(tx_permit), .rx_thresh_irq(rx_thresh_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic int lvl_prog(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction
    function automatic int lvl_stop(input int s);
        return (s == 0) ? 4 : (s == 1) ? 8 : (s == 2) ? 14 : 16;
    endfunction
    function automatic int lvl_res(input int s);
        return (s == 0) ? 1 : lvl_prog(s) - 1;
    endfunction

    task automatic t_reset;
        check("R1 permit after reset", tx_permit, 1);
        check("R1 irq after reset", rx_thresh_irq, 0);
        auto_rts_en = 1'b1;
        #1;
        check("R1 rts in GO after reset", rts_out, 0);
        auto_rts_en = 1'b0;
    endtask

    task automatic t_ladder(input int s);
        trig_sel = 2'(s);
        rx_count = '0;
        auto_rts_en = 1'b1;
        step();
        check("R5 start go", rts_out, 0);
        check("R3 irq low at empty", rx_thresh_irq, 0);
        rx_count = 5'(lvl_prog(s));
        step();
        check("R2/R3 irq at programmed level", rx_thresh_irq, 1);
        check("R6 hold go below stop", rts_out, 0);
        rx_count = 5'(lvl_stop(s) - 1);
        step();
        check("R6 go just under stop", rts_out, 0);
        rx_count = 5'(lvl_stop(s));
        step();
        check("R2/R4 stop at next rung", rts_out, 1);
        rx_count = 5'(lvl_res(s));
        step();
        check("R6 hold stop at resume level", rts_out, 1);
        rx_count = 5'(lvl_res(s) - 1);
        step();
        check("R5 resume below level minus one", rts_out, 0);
        check("R3 irq cleared below level", rx_thresh_irq, 0);
        rx_count = 5'(lvl_res(s));
        step();
        check("R6 hold go at resume level", rts_out, 0);
        auto_rts_en = 1'b0;
        rx_count = '0;
        step();
    endtask

    task automatic t_sw_rts;
        trig_sel = 2'd2;
        auto_rts_en = 1'b1;
        rx_count = 5'd16;
        step();
        check("R4 stop at full", rts_out, 1);
        auto_rts_en = 1'b0;
        sw_rts = 1'b0;
        #1 check("R7 follows sw 0", rts_out, 0);
        sw_rts = 1'b1;
        #1 check("R7 follows sw 1", rts_out, 1);
        step();
        check("R3 irq off when auto off", rx_thresh_irq, 0);
        rx_count = 5'd10;
        step();
        auto_rts_en = 1'b1;
        #1 check("R7 forced GO on re-enable", rts_out, 0);
        step();
        check("R7 stays GO in band", rts_out, 0);
        auto_rts_en = 1'b0;
        sw_rts = 1'b0;
        rx_count = '0;
        step();
    endtask

    task automatic t_cts;
        auto_cts_en = 1'b0;
        tx_idle = 1'b1;
        cts_in = 1'b1;
        step(4);
        check("R11 cts ignored when off", tx_permit, 1);
        auto_cts_en = 1'b1;
        tx_idle = 1'b0;
        step(5);
        check("R10 frozen mid-character", tx_permit, 1);
        tx_idle = 1'b1;
        step();
        check("R9 hold at boundary", tx_permit, 0);
        cts_in = 1'b0;
        step(2);
        check("R8 still held after two edges", tx_permit, 0);
        step();
        check("R8/R9 resumes on third edge", tx_permit, 1);
        cts_in = 1'b1;
        tx_idle = 1'b0;
        step(4);
        check("R10 no stop mid-character", tx_permit, 1);
        tx_idle = 1'b1;
        step();
        check("R9 stop at next boundary", tx_permit, 0);
        auto_cts_en = 1'b0;
        step();
        check("R11 release when disabled", tx_permit, 1);
        cts_in = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        for (int s = 0; s < 4; s++) t_ladder(s);
        t_sw_rts();
        t_cts();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule